// File: doc/BRIEF.md
# Exception and Interrupt Control Registers

This unit is the small bank of system-control state that a simple multicycle or pipelined core uses to react to traps. It holds four registers:

- a faulting-address register;
- a status register whose only live bit is the global interrupt enable;
- a cause register carrying a 4-bit trap code;
- an exception return address.

A synchronous exception, such as an arithmetic overflow or a bad memory access, is reported by the core together with a nonzero code. Asynchronous device interrupts arrive on a vector of request lines. The unit accepts a device interrupt only in a cycle that the core marks as an instruction boundary, so the instruction in flight always completes.

When a trap is accepted, the unit does four things. It pulses a take signal and presents the fixed handler address for the fetch redirect. It saves the current instruction address as the return address and records the trap code. It clears the interrupt enable so that the handler is not re-entered. Software reaches the registers through a combinational move-from read port and a single move-to write port, both addressed by register number.

Top module: `trap_ctl_regs`

## Requirements
- R1: Reset clears the faulting-address, status, cause and return-address registers. While reset is held, all four read as zero through the move-from port and the take output is low.
- R2: The move-from port returns the registers at these numbers:
  - 8: faulting address
  - 12: status, with the enable in bit 0
  - 13: cause
  - 14: return address
  
  Every other register number reads as zero.
- R3: The cause register presents the trap code in bits 5 down to 2. Bits 1 to 0 and all bits above 5 read as zero.
- R4: A device interrupt is taken only when three conditions hold in the same cycle: at least one request line is high, the boundary input is high, and the interrupt enable is 1. Otherwise no device interrupt is taken.
- R5: When a device interrupt is taken, take_o is high and vector_o equals the handler address parameter in that same cycle. On the next clock edge, the return address becomes the current instruction address, the cause code becomes 0 and the interrupt enable becomes 0.
- R6: A reported exception is taken whether or not the enable bit is set and whether or not the boundary input is high. The exception's own code is recorded, the current instruction address is saved and the enable bit is cleared.
- R7: When an exception and an acceptable device interrupt occur in the same cycle, the exception is taken and its code is recorded.
- R8: The faulting-address register loads only when a taken exception also flags a valid faulting address. It keeps its value otherwise, including across traps that do not flag one.
- R9: Move-to writes change only two registers. A write to status stores bit 0 of the data as the enable. A write to the return address stores the whole word. Writes to numbers 8 and 13 have no effect.
- R10: When a trap is taken in the same cycle as a move-to write to status or to the return address, the trap's values win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Core marks an instruction boundary where a device interrupt may be taken |
| irq_i | input | N_IRQ | Device interrupt request lines |
| exc_valid_i | input | 1 | Synchronous exception reported this cycle |
| exc_code_i | input | 4 | Code of the reported exception |
| cur_pc_i | input | XLEN | Address of the current or interrupted instruction |
| badaddr_valid_i | input | 1 | The exception carries a faulting address |
| badaddr_i | input | XLEN | Faulting address |
| mt_en_i | input | 1 | Move-to write strobe |
| mt_num_i | input | 5 | Move-to register number |
| mt_data_i | input | XLEN | Move-to write data |
| mf_num_i | input | 5 | Move-from register number |
| mf_data_o | output | XLEN | Move-from read data |
| take_o | output | 1 | A trap is taken this cycle; fetch is redirected |
| vector_o | output | XLEN | Handler address for the redirect |

## Verification
Two pairs of events can land in the same cycle. The first pair is an exception and an acceptable device interrupt. The second pair is a taken trap and a move-to write aimed at status or the return address. The table-driven bench provokes both pairs by asserting the colliding inputs together in one vector. It then reads every register through the move-from port on the following cycle. An exception colliding with an interrupt passes only if the exception code was recorded. A trap colliding with a write passes only if the saved instruction address and the cleared enable replaced the written values.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int unsigned CODE_W   = 4;
    localparam int unsigned CODE_LSB = 2;
    localparam int unsigned RNUM_W   = 5;

    localparam logic [RNUM_W-1:0] RN_BADADDR = 5'd8;
    localparam logic [RNUM_W-1:0] RN_STATUS  = 5'd12;
    localparam logic [RNUM_W-1:0] RN_CAUSE   = 5'd13;
    localparam logic [RNUM_W-1:0] RN_EPC     = 5'd14;

    localparam logic [CODE_W-1:0] CODE_DEVICE_IRQ = 4'd0;

endpackage

// File: rtl/trap_select.sv
module trap_select
    import trap_pkg::*;
#(
    parameter int unsigned N_IRQ = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              boundary_i,
    input  logic [N_IRQ-1:0]  irq_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              ie_i,
    output logic              take_o,
    output logic              is_exc_o,
    output logic [CODE_W-1:0] code_o
);

    logic irq_any;
    logic irq_ok;

    assign irq_any = |irq_i;

    always_comb begin
        irq_ok   = irq_any && boundary_i && ie_i;
        take_o   = exc_valid_i || irq_ok;
        is_exc_o = exc_valid_i;
        code_o   = exc_valid_i ? exc_code_i : CODE_DEVICE_IRQ;
    end

    // R7
    exc_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_valid_i |-> (take_o && is_exc_o && code_o == exc_code_i));

    // R4
    masked_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!exc_valid_i && (!ie_i || !boundary_i)) |-> !take_o);

endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
    import trap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              take_i,
    input  logic              is_exc_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic              badaddr_valid_i,
    input  logic [XLEN-1:0]   badaddr_i,
    input  logic              mt_en_i,
    input  logic [RNUM_W-1:0] mt_num_i,
    input  logic [XLEN-1:0]   mt_data_i,
    output logic [XLEN-1:0]   bad_o,
    output logic              ie_o,
    output logic [CODE_W-1:0] code_o,
    output logic [XLEN-1:0]   epc_o
);

    typedef struct packed {
        logic [XLEN-1:0]   bad;
        logic              ie;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   epc;
    } csr_t;

    csr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mt_en_i) begin
            case (mt_num_i)
                RN_STATUS: st_d.ie  = mt_data_i[0];
                RN_EPC:    st_d.epc = mt_data_i;
                default:   ;
            endcase
        end
        if (take_i) begin
            st_d.ie   = 1'b0;
            st_d.epc  = cur_pc_i;
            st_d.code = code_i;
            if (is_exc_i && badaddr_valid_i) begin
                st_d.bad = badaddr_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bad_o  = st_q.bad;
    assign ie_o   = st_q.ie;
    assign code_o = st_q.code;
    assign epc_o  = st_q.epc;

    // R5
    epc_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> (st_q.epc == $past(cur_pc_i) && !st_q.ie));

    // R8
    badaddr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(take_i && is_exc_i && badaddr_valid_i) |=> $stable(st_q.bad));

    // R9
    cause_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_i |=> $stable(st_q.code));

endmodule

// File: rtl/trap_read_mux.sv
module trap_read_mux
    import trap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [RNUM_W-1:0] num_i,
    input  logic [XLEN-1:0]   bad_i,
    input  logic              ie_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   epc_i,
    output logic [XLEN-1:0]   data_o
);

    localparam int unsigned CODE_MSB = CODE_LSB + CODE_W - 1;

    always_comb begin
        data_o = '0;
        case (num_i)
            RN_BADADDR: data_o = bad_i;
            RN_STATUS:  data_o[0] = ie_i;
            RN_CAUSE:   data_o[CODE_MSB:CODE_LSB] = code_i;
            RN_EPC:     data_o = epc_i;
            default:    data_o = '0;
        endcase
    end

    // R3
    cause_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (num_i == RN_CAUSE) |-> (data_o[CODE_LSB-1:0] == '0
                                 && (data_o >> (CODE_MSB + 1)) == '0));

endmodule

// File: rtl/trap_ctl_regs.sv
module trap_ctl_regs
    import trap_pkg::*;
#(
    parameter int unsigned     XLEN        = 32,
    parameter int unsigned     N_IRQ       = 4,
    parameter logic [XLEN-1:0] TRAP_VECTOR = 32'h8000_0080
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              boundary_i,
    input  logic [N_IRQ-1:0]  irq_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic              badaddr_valid_i,
    input  logic [XLEN-1:0]   badaddr_i,
    input  logic              mt_en_i,
    input  logic [RNUM_W-1:0] mt_num_i,
    input  logic [XLEN-1:0]   mt_data_i,
    input  logic [RNUM_W-1:0] mf_num_i,
    output logic [XLEN-1:0]   mf_data_o,
    output logic              take_o,
    output logic [XLEN-1:0]   vector_o
);

    logic              take;
    logic              is_exc;
    logic [CODE_W-1:0] sel_code;
    logic [XLEN-1:0]   bad_q;
    logic              ie_q;
    logic [CODE_W-1:0] code_q;
    logic [XLEN-1:0]   epc_q;

    trap_select #(.N_IRQ(N_IRQ)) sel_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .boundary_i  (boundary_i),
        .irq_i       (irq_i),
        .exc_valid_i (exc_valid_i),
        .exc_code_i  (exc_code_i),
        .ie_i        (ie_q),
        .take_o      (take),
        .is_exc_o    (is_exc),
        .code_o      (sel_code)
    );

    trap_csr_file #(.XLEN(XLEN)) csr_i (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .take_i          (take),
        .is_exc_i        (is_exc),
        .code_i          (sel_code),
        .cur_pc_i        (cur_pc_i),
        .badaddr_valid_i (badaddr_valid_i),
        .badaddr_i       (badaddr_i),
        .mt_en_i         (mt_en_i),
        .mt_num_i        (mt_num_i),
        .mt_data_i       (mt_data_i),
        .bad_o           (bad_q),
        .ie_o            (ie_q),
        .code_o          (code_q),
        .epc_o           (epc_q)
    );

    trap_read_mux #(.XLEN(XLEN)) rd_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .num_i  (mf_num_i),
        .bad_i  (bad_q),
        .ie_i   (ie_q),
        .code_i (code_q),
        .epc_i  (epc_q),
        .data_o (mf_data_o)
    );

    assign take_o   = take;
    assign vector_o = TRAP_VECTOR;

    // R10
    trap_over_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && mt_en_i) |=> (!ie_q && epc_q == $past(cur_pc_i)));

endmodule

// File: tb/trap_ctl_regs_tb.sv
module trap_ctl_regs_tb_top;

    localparam int          XLEN   = 32;
    localparam int          N_IRQ  = 4;
    localparam logic [31:0] VECTOR = 32'h8000_0080;
    localparam time         CYC    = 20ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        boundary;
    logic [3:0]  irq;
    logic        exc_valid;
    logic [3:0]  exc_code;
    logic [31:0] cur_pc;
    logic        bad_valid;
    logic [31:0] bad_addr;
    logic        mt_en;
    logic [4:0]  mt_num;
    logic [31:0] mt_data;
    logic [4:0]  mf_num;
    logic [31:0] mf_data;
    logic        take;
    logic [31:0] vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CYC/2) clk = ~clk;

    trap_ctl_regs #(.XLEN(XLEN), .N_IRQ(N_IRQ), .TRAP_VECTOR(VECTOR)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .irq_i(irq),
        .exc_valid_i(exc_valid), .exc_code_i(exc_code), .cur_pc_i(cur_pc),
        .badaddr_valid_i(bad_valid), .badaddr_i(bad_addr), .mt_en_i(mt_en),
        .mt_num_i(mt_num), .mt_data_i(mt_data), .mf_num_i(mf_num),
        .mf_data_o(mf_data), .take_o(take), .vector_o(vec)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        bnd;
        logic [3:0]  irq;
        logic        exc;
        logic [3:0]  code;
        logic [31:0] pc;
        logic        bv;
        logic [31:0] ba;
        logic        we;
        logic [4:0]  wnum;
        logic [31:0] wdata;
        logic        e_take;
        logic        e_ie;
        logic [31:0] e_epc;
        logic [3:0]  e_code;
        logic [31:0] e_bad;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{"R4",  1, 4'b0001, 0, 0, 32'h0,   0, 32'h0,    0, 5'd0,  32'h0,        0, 0, 32'h0,   4'd0,  32'h0},
        '{"R9",  0, 4'b0000, 0, 0, 32'h0,   0, 32'h0,    1, 5'd12, 32'h1,        0, 1, 32'h0,   4'd0,  32'h0},
        '{"R4",  0, 4'b0001, 0, 0, 32'h0,   0, 32'h0,    0, 5'd0,  32'h0,        0, 1, 32'h0,   4'd0,  32'h0},
        '{"R5",  1, 4'b0010, 0, 0, 32'h100, 0, 32'h0,    0, 5'd0,  32'h0,        1, 0, 32'h100, 4'd0,  32'h0},
        '{"R9",  0, 4'b0000, 0, 0, 32'h0,   0, 32'h0,    1, 5'd14, 32'h204,      0, 0, 32'h204, 4'd0,  32'h0},
        '{"R9",  0, 4'b0000, 0, 0, 32'h0,   0, 32'h0,    1, 5'd13, 32'hFF,       0, 0, 32'h204, 4'd0,  32'h0},
        '{"R9",  0, 4'b0000, 0, 0, 32'h0,   0, 32'h0,    1, 5'd8,  32'hDEAD,     0, 0, 32'h204, 4'd0,  32'h0},
        '{"R6",  0, 4'b0000, 1, 12, 32'h300, 0, 32'h55,  0, 5'd0,  32'h0,        1, 0, 32'h300, 4'd12, 32'h0},
        '{"R9",  0, 4'b0000, 0, 0, 32'h0,   0, 32'h0,    1, 5'd12, 32'h1,        0, 1, 32'h300, 4'd12, 32'h0},
        '{"R7",  1, 4'b1000, 1, 4, 32'h400, 1, 32'h1234, 0, 5'd0,  32'h0,        1, 0, 32'h400, 4'd4,  32'h1234},
        '{"R9",  0, 4'b0000, 0, 0, 32'h0,   0, 32'h0,    1, 5'd12, 32'hFFFF_FFFF, 0, 1, 32'h400, 4'd4,  32'h1234},
        '{"R10", 1, 4'b0100, 0, 0, 32'h500, 0, 32'h0,    1, 5'd14, 32'h999,      1, 0, 32'h500, 4'd0,  32'h1234},
        '{"R8",  0, 4'b0000, 1, 5, 32'h600, 0, 32'hBEEF, 0, 5'd0,  32'h0,        1, 0, 32'h600, 4'd5,  32'h1234},
        '{"R10", 0, 4'b0000, 1, 3, 32'h700, 0, 32'h0,    1, 5'd12, 32'h1,        1, 0, 32'h700, 4'd3,  32'h1234}
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        boundary  = 1'b0;
        irq       = '0;
        exc_valid = 1'b0;
        exc_code  = '0;
        cur_pc    = '0;
        bad_valid = 1'b0;
        bad_addr  = '0;
        mt_en     = 1'b0;
        mt_num    = '0;
        mt_data   = '0;
    endtask

    task automatic read_reg(input logic [4:0] n, output logic [31:0] d);
        mf_num = n;
        #1;
        d = mf_data;
    endtask

    task automatic check_all(input string tag, input logic ie, input logic [31:0] epc,
                             input logic [3:0] code, input logic [31:0] bad);
        logic [31:0] d;
        read_reg(5'd12, d); check(tag, "status",    d, {31'b0, ie});
        read_reg(5'd14, d); check(tag, "ret addr",  d, epc);
        read_reg(5'd13, d); check(tag, "cause",     d, {26'b0, code, 2'b00});
        read_reg(5'd8,  d); check(tag, "bad addr",  d, bad);
    endtask

    initial begin
        #(CYC * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle();
        mf_num = '0;
        rst_n  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_all("R1", 1'b0, 32'h0, 4'd0, 32'h0);
        check("R1", "take", {31'b0, take}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            boundary  = VECS[i].bnd;
            irq       = VECS[i].irq;
            exc_valid = VECS[i].exc;
            exc_code  = VECS[i].code;
            cur_pc    = VECS[i].pc;
            bad_valid = VECS[i].bv;
            bad_addr  = VECS[i].ba;
            mt_en     = VECS[i].we;
            mt_num    = VECS[i].wnum;
            mt_data   = VECS[i].wdata;
            #5;
            check($sformatf("%s", VECS[i].tag), "take", {31'b0, take}, {31'b0, VECS[i].e_take});
            if (VECS[i].e_take)
                check($sformatf("%s", VECS[i].tag), "vector", vec, VECTOR);
            @(negedge clk);
            idle();
            check_all($sformatf("%s", VECS[i].tag), VECS[i].e_ie, VECS[i].e_epc,
                      VECS[i].e_code, VECS[i].e_bad);
        end

        // R2 unused register numbers read zero
        read_reg(5'd0,  d); check("R2", "num 0",  d, 32'h0);
        read_reg(5'd9,  d); check("R2", "num 9",  d, 32'h0);
        read_reg(5'd15, d); check("R2", "num 15", d, 32'h0);
        read_reg(5'd31, d); check("R2", "num 31", d, 32'h0);

        // R3 cause padding with code 3 recorded: exact word 0x0000000C
        read_reg(5'd13, d); check("R3", "cause word", d, 32'h0000_000C);

        // R4 request lines without enable at a boundary (enable is 0 now)
        @(negedge clk);
        boundary = 1'b1; irq = 4'b1111;
        #5 check("R4", "take masked", {31'b0, take}, 32'h0);
        @(negedge clk);
        idle();
        check_all("R4", 1'b0, 32'h700, 4'd3, 32'h1234);

        // R1 reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_all("R1", 1'b0, 32'h0, 4'd0, 32'h0);
        check("R1", "take", {31'b0, take}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule